// File: doc/BRIEF.md
# Pulse-and-Verify Byte Programming Controller

This controller writes a block of bytes from a source buffer into a one-time-programmable memory. Each location is programmed one pulse at a time. A pulse is one strobe of fixed width on the program port. After every pulse the controller reads the location back and compares it with the source byte. When the byte matches, the controller moves to the next address. When a byte is still wrong after the pulse limit, the whole job stops with a failure. Programming can only clear bits from 1 to 0, and an erased cell reads all ones. A source bit of 1 over a stored 0 therefore never verifies and runs into the limit.

While the pulse/verify phase runs, one voltage-select output asks the supply logic for raised core and program rails. Once the last address matches, the select drops to nominal. After a settling delay the controller reads every byte again and compares it with the source. Any difference gives a fail; a clean pass gives a pass. A one-cycle `done` marks the end of each job. The `pass` and `fail` flags stay set until the next accepted `start`.

The source and memory read ports are combinational: each returns the byte for the address the controller drives in the same cycle.

Top module: `otp_burn_ctrl`

## Requirements
- R1: A job starts at address 0 and programs addresses in strictly ascending order, one at a time, up to address 2**ADDR_W-1.
- R2: Every program strobe (`mem_pgm`) stays high for exactly PULSE_CYC consecutive cycles.
- R3: `mem_addr` and `mem_wdata` stay unchanged for at least SETUP_CYC cycles before a strobe rises, throughout the strobe, and for at least HOLD_CYC cycles after it falls.
- R4: Each strobe is followed by a verify read (`mem_rd` high) of the same address, and a read never overlaps a strobe. A match moves on to the next address; a mismatch issues another strobe to the same address.
- R5: If a byte still mismatches after MAX_PULSES strobes, the job ends with `fail`. No further strobe is issued and no final compare runs.
- R6: `vsel_hi` is 1 through the whole pulse/verify phase and 0 at all other times. Strobes occur only while it is 1.
- R7: After any change of `vsel_hi`, at least SETTLE_CYC cycles pass before the next strobe or the next read.
- R8: After the last address verifies, every address from 0 upward is read with `vsel_hi` at 0 and compared with the source. The first mismatch ends the job with `fail`; if all bytes match, the job ends with `pass`.
- R9: `done` is high for exactly one cycle per job, with exactly one of `pass`/`fail` set. The pair is never 1 together, holds until the next accepted `start`, and is cleared in the cycle after that start.
- R10: `start` is ignored while a job is running.
- R11: After reset, `done`, `pass`, `fail`, `vsel_hi`, `mem_pgm` and `mem_rd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (taken only when idle) |
| done | output | 1 | One-cycle end-of-job marker |
| pass | output | 1 | Job completed with all bytes correct |
| fail | output | 1 | Job failed (pulse limit or final compare) |
| src_addr | output | ADDR_W | Source buffer read address |
| src_data | input | DATA_W | Source byte at `src_addr` (combinational) |
| mem_addr | output | ADDR_W | Target memory address |
| mem_wdata | output | DATA_W | Byte presented for programming |
| mem_pgm | output | 1 | Program strobe |
| mem_rd | output | 1 | Read/compare cycle marker |
| mem_rdata | input | DATA_W | Memory byte at `mem_addr` (combinational) |
| vsel_hi | output | 1 | 1 requests raised programming rails, 0 nominal |

## Verification
The bound checker watches the port-level rules on every cycle: strobe width, address and data stability around a strobe, strobes only at raised voltage, settling after a voltage change, no read during a strobe, the per-address pulse ceiling, and the done/pass/fail protocol. The outcome of the algorithm needs a memory model that responds to pulses, so only the bench scenarios can show it. These scenarios cover bytes that need several pulses, exactly the limit, or never verify, a stuck-low bit, a byte that is correct only at raised voltage, and a start issued during a job.

// File: rtl/otp_burn_pkg.sv
`timescale 1ns/1ps
package otp_burn_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RAISE,   // raised rails settling
    ST_SETUP,   // address/data setup before strobe
    ST_PULSE,   // strobe high
    ST_HOLD,    // address/data hold after strobe
    ST_VERIFY,  // read back at raised rails
    ST_LOWER,   // nominal rails settling
    ST_CMP,     // whole-block compare at nominal
    ST_FINISH   // done cycle
  } burn_state_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // A phase of n cycles loads n-1 into the down counter (minimum one cycle).
  function automatic int unsigned phase_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic logic in_prog_phase(input burn_state_e s);
    return (s == ST_RAISE) || (s == ST_SETUP) || (s == ST_PULSE) ||
           (s == ST_HOLD)  || (s == ST_VERIFY);
  endfunction

endpackage

// File: rtl/otp_burn_timer.sv
`timescale 1ns/1ps
module otp_burn_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/otp_burn_addr_seq.sv
`timescale 1ns/1ps
module otp_burn_addr_seq #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr <= '0;
    else if (clr) addr <= '0;
    else if (inc) addr <= addr + ADDR_W'(1);
  end

  assign at_last = &addr;
endmodule

// File: rtl/otp_burn_tries.sv
`timescale 1ns/1ps
module otp_burn_tries #(
  parameter int unsigned MAX_PULSES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int unsigned CW = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

  logic [CW-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     used <= '0;
    else if (clr)                   used <= '0;
    else if (inc && used != LIMIT)  used <= used + CW'(1);
  end

  assign at_limit = (used >= LIMIT);
endmodule

// File: rtl/otp_burn_ctrl.sv
`timescale 1ns/1ps
module otp_burn_ctrl
  import otp_burn_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PULSE_CYC  = 25000,
  parameter int unsigned SETUP_CYC  = 500,
  parameter int unsigned HOLD_CYC   = 500,
  parameter int unsigned SETTLE_CYC = 250,
  parameter int unsigned MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_pgm,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              vsel_hi
);
  localparam int unsigned LONGEST = max_of4(PULSE_CYC, SETUP_CYC, HOLD_CYC, SETTLE_CYC);
  localparam int unsigned TW      = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] LD_PULSE  = TW'(phase_load(PULSE_CYC));
  localparam logic [TW-1:0] LD_SETUP  = TW'(phase_load(SETUP_CYC));
  localparam logic [TW-1:0] LD_HOLD   = TW'(phase_load(HOLD_CYC));
  localparam logic [TW-1:0] LD_SETTLE = TW'(phase_load(SETTLE_CYC));

  burn_state_e state, nxt;

  // named internal events
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          addr_clr, addr_inc, addr_last;
  logic          try_clr, try_inc, try_limit;
  logic          set_pass, set_fail, clr_result;
  logic          verify_match;
  logic [ADDR_W-1:0] cur_addr;

  otp_burn_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  otp_burn_addr_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
    .addr(cur_addr), .at_last(addr_last)
  );

  otp_burn_tries #(.MAX_PULSES(MAX_PULSES)) tries_i (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .at_limit(try_limit)
  );

  assign verify_match = (mem_rdata == src_data);

  always_comb begin
    nxt        = state;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    addr_clr   = 1'b0;
    addr_inc   = 1'b0;
    try_clr    = 1'b0;
    try_inc    = 1'b0;
    set_pass   = 1'b0;
    set_fail   = 1'b0;
    clr_result = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        nxt = ST_RAISE; tmr_load = 1'b1; tmr_val = LD_SETTLE;
        addr_clr = 1'b1; try_clr = 1'b1; clr_result = 1'b1;
      end
      ST_RAISE: if (tmr_zero) begin
        nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = LD_SETUP;
      end
      ST_SETUP: if (tmr_zero) begin
        nxt = ST_PULSE; tmr_load = 1'b1; tmr_val = LD_PULSE; try_inc = 1'b1;
      end
      ST_PULSE: if (tmr_zero) begin
        nxt = ST_HOLD; tmr_load = 1'b1; tmr_val = LD_HOLD;
      end
      ST_HOLD: if (tmr_zero) nxt = ST_VERIFY;
      ST_VERIFY: begin
        if (verify_match) begin
          if (addr_last) begin
            nxt = ST_LOWER; tmr_load = 1'b1; tmr_val = LD_SETTLE;
          end else begin
            nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = LD_SETUP;
            addr_inc = 1'b1; try_clr = 1'b1;
          end
        end else if (try_limit) begin
          nxt = ST_FINISH; set_fail = 1'b1;
        end else begin
          nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = LD_SETUP;
        end
      end
      ST_LOWER: if (tmr_zero) begin
        nxt = ST_CMP; addr_clr = 1'b1;
      end
      ST_CMP: begin
        if (!verify_match) begin
          nxt = ST_FINISH; set_fail = 1'b1;
        end else if (addr_last) begin
          nxt = ST_FINISH; set_pass = 1'b1;
        end else begin
          addr_inc = 1'b1;
        end
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pass  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= nxt;
      if (clr_result) begin
        pass <= 1'b0;
        fail <= 1'b0;
      end else begin
        if (set_pass) pass <= 1'b1;
        if (set_fail) fail <= 1'b1;
      end
    end
  end

  assign done      = (state == ST_FINISH);
  assign mem_pgm   = (state == ST_PULSE);
  assign mem_rd    = (state == ST_VERIFY) || (state == ST_CMP);
  assign vsel_hi   = in_prog_phase(state);
  assign src_addr  = cur_addr;
  assign mem_addr  = cur_addr;
  assign mem_wdata = src_data;
endmodule

// File: rtl/otp_burn_chk.sv
`timescale 1ns/1ps
module otp_burn_chk #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PULSE_CYC  = 25000,
  parameter int unsigned SETTLE_CYC = 250,
  parameter int unsigned MAX_PULSES = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_pgm,
  input logic              mem_rd,
  input logic              vsel_hi
);
  localparam int unsigned SAT = 32'h4000_0000;

  logic              pgm_q, v_q;
  int unsigned       pgm_run, v_age, try_cnt;
  logic [ADDR_W-1:0] last_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_q   <= 1'b0;
      v_q     <= 1'b0;
      pgm_run <= 0;
      v_age   <= SAT;
      try_cnt <= 0;
      last_a  <= '0;
    end else begin
      pgm_q   <= mem_pgm;
      v_q     <= vsel_hi;
      pgm_run <= mem_pgm ? pgm_run + 32'd1 : 32'd0;
      if (vsel_hi != v_q)  v_age <= 32'd1;
      else if (v_age < SAT) v_age <= v_age + 32'd1;
      if (done) begin
        try_cnt <= 0;
      end else if (mem_pgm && !pgm_q) begin
        try_cnt <= (mem_addr == last_a && try_cnt != 0) ? try_cnt + 32'd1 : 32'd1;
        last_a  <= mem_addr;
      end
    end
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_q && !mem_pgm) |-> (pgm_run == PULSE_CYC));

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pgm || pgm_q) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_rd_not_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_pgm && mem_rd));

  assert_pulse_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    try_cnt <= MAX_PULSES);

  assert_pulse_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pgm |-> vsel_hi);

  assert_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_pgm && !pgm_q) || (mem_rd && !vsel_hi && v_q == vsel_hi && !$past(mem_rd)))
      |-> (v_age >= SETTLE_CYC));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_done_has_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pass || fail) && !start) |=> (pass || fail));
endmodule

bind otp_burn_ctrl otp_burn_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC),
  .SETTLE_CYC(SETTLE_CYC), .MAX_PULSES(MAX_PULSES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass), .fail(fail),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_pgm(mem_pgm), .mem_rd(mem_rd),
  .vsel_hi(vsel_hi)
);

// File: tb/otp_burn_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_burn_ctrl_tb_top;
  localparam int AW = 3;
  localparam int N  = 1 << AW;
  localparam int PC = 6;
  localparam int SU = 3;
  localparam int HO = 2;
  localparam int ST = 4;
  localparam int MP = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, pass, fail, mem_pgm, mem_rd, vsel_hi;
  logic [AW-1:0] src_addr, mem_addr;
  logic [7:0] src_data, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  // bench-side images
  logic [7:0] src_img    [N];
  logic [7:0] preset_img [N];
  logic [7:0] weak_img   [N];
  int         need       [N];
  logic [7:0] stored     [N];
  int         pulses_at  [N];

  assign src_data  = src_img[src_addr];
  assign mem_rdata = stored[mem_addr] | (vsel_hi ? 8'h00 : weak_img[mem_addr]);

  otp_burn_ctrl #(
    .ADDR_W(AW), .DATA_W(8), .PULSE_CYC(PC), .SETUP_CYC(SU), .HOLD_CYC(HO),
    .SETTLE_CYC(ST), .MAX_PULSES(MP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass), .fail(fail),
    .src_addr(src_addr), .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_pgm(mem_pgm), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .vsel_hi(vsel_hi)
  );

  int n_chk = 0;
  int n_fail = 0;

  // monitor state (written only by the monitor)
  int load_seq = 0;
  int load_seen = 0;
  int n_pulses, n_ver, n_nom, n_done, first_addr, last_paddr;
  int v_width, v_setup, v_hold, v_settle, v_order, v_vsel, v_excl;
  int run_len, fall_age, a_age, v_age;
  logic pgm_prev = 1'b0, v_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  logic [7:0] wd_prev = '0;

  always @(negedge clk) begin
    if (load_seq != load_seen) begin
      load_seen = load_seq;
      for (int i = 0; i < N; i++) begin
        stored[i] = preset_img[i];
        pulses_at[i] = 0;
      end
      n_pulses = 0; n_ver = 0; n_nom = 0; n_done = 0;
      first_addr = -1; last_paddr = -1;
      v_width = 0; v_setup = 0; v_hold = 0; v_settle = 0;
      v_order = 0; v_vsel = 0; v_excl = 0;
      run_len = 0; fall_age = 1000; a_age = 1000; v_age = 1000;
    end else if (rst_n) begin
      if (((mem_addr != addr_prev) || (mem_wdata != wd_prev)) && fall_age <= HO) v_hold++;
      if (!mem_pgm && pgm_prev) begin
        if (run_len != PC) v_width++;
        fall_age = 1;
      end else fall_age++;
      a_age = ((mem_addr != addr_prev) || (mem_wdata != wd_prev)) ? 0 : a_age + 1;
      v_age = (vsel_hi != v_prev) ? 0 : v_age + 1;
      if (mem_pgm && !pgm_prev) begin
        n_pulses++;
        pulses_at[mem_addr]++;
        if (first_addr < 0) first_addr = int'(mem_addr);
        if (int'(mem_addr) < last_paddr) v_order++;
        last_paddr = int'(mem_addr);
        if (a_age < SU) v_setup++;
        if (v_age < ST) v_settle++;
        if (pulses_at[mem_addr] >= ((need[mem_addr] == 0) ? 1 : need[mem_addr]))
          stored[mem_addr] = stored[mem_addr] & mem_wdata;
        run_len = 0;
      end
      if (mem_pgm) run_len++;
      if (mem_pgm && !vsel_hi) v_vsel++;
      if (mem_pgm && mem_rd) v_excl++;
      if (mem_rd) begin
        if (vsel_hi) n_ver++;
        else begin
          n_nom++;
          if (v_age < ST) v_settle++;
        end
      end
      if (done) n_done++;
    end
    pgm_prev  = mem_pgm;
    v_prev    = vsel_hi;
    addr_prev = mem_addr;
    wd_prev   = mem_wdata;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // fresh erased memory, default source pattern, every byte takes on first pulse
  task automatic prep_default();
    for (int i = 0; i < N; i++) begin
      src_img[i]    = 8'((i * 37 + 11) ^ 8'hA5);
      preset_img[i] = 8'hFF;
      weak_img[i]   = 8'h00;
      need[i]       = 1;
    end
    src_img[5] = 8'hFF;
    src_img[4] = 8'h2C;
  endtask

  task automatic commit();
    @(negedge clk);
    load_seq++;
    repeat (2) @(negedge clk);
  endtask

  logic res_pass, res_fail, after_start_pass, after_start_fail;
  int   job_cycles;

  task automatic run_job(input bit poke_busy);
    bit got;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    after_start_pass = pass;
    after_start_fail = fail;
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    job_cycles = 0;
    while (!got && job_cycles < 5000) begin
      if (done) got = 1'b1;
      else begin
        @(negedge clk);
        job_cycles++;
      end
    end
    chk("R9", "done seen", int'(got), 1);
    res_pass = pass;
    res_fail = fail;
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
    chk("R6", "vsel low after job", int'(vsel_hi), 0);
  endtask

  task automatic scen_reset();
    chk("R11", "outputs after reset",
        int'({done, pass, fail, vsel_hi, mem_pgm, mem_rd}), 0);
  endtask

  task automatic scen_clean();
    prep_default();
    commit();
    run_job(1'b0);
    chk("R8", "pass", int'(res_pass), 1);
    chk("R8", "fail", int'(res_fail), 0);
    chk("R4", "total strobes", n_pulses, N);
    chk("R1", "first strobe address", first_addr, 0);
    chk("R1", "order violations", v_order, 0);
    chk("R1", "last address strobed", pulses_at[N-1], 1);
    chk("R2", "width violations", v_width, 0);
    chk("R3", "setup violations", v_setup, 0);
    chk("R3", "hold violations", v_hold, 0);
    chk("R4", "verify reads", n_ver, N);
    chk("R4", "read during strobe", v_excl, 0);
    chk("R4", "erased-value byte strobes", pulses_at[5], 1);
    chk("R6", "strobe at nominal", v_vsel, 0);
    chk("R7", "settle violations", v_settle, 0);
    chk("R8", "nominal compare reads", n_nom, N);
    chk("R9", "done count", n_done, 1);
    for (int i = 0; i < N; i++) chk("R4", "stored byte", int'(stored[i]), int'(src_img[i]));
    repeat (10) @(negedge clk);
    chk("R9", "pass held", int'(pass), 1);
    chk("R9", "fail held low", int'(fail), 0);
  endtask

  task automatic scen_retries();
    prep_default();
    need[2] = 5;
    need[6] = MP;
    commit();
    run_job(1'b0);
    chk("R9", "pass cleared after start", int'(after_start_pass), 0);
    chk("R4", "five-pulse byte", pulses_at[2], 5);
    chk("R5", "byte at exact limit", pulses_at[6], MP);
    chk("R5", "limit byte still passes", int'(res_pass), 1);
    chk("R4", "total strobes", n_pulses, N - 2 + 5 + MP);
    chk("R2", "width violations", v_width, 0);
    chk("R3", "hold violations", v_hold, 0);
  endtask

  task automatic scen_never();
    prep_default();
    need[3] = 255;
    commit();
    run_job(1'b0);
    chk("R5", "fail", int'(res_fail), 1);
    chk("R5", "pass", int'(res_pass), 0);
    chk("R5", "strobes on dead byte", pulses_at[3], MP);
    chk("R5", "no strobe past dead byte", pulses_at[4], 0);
    chk("R5", "no final compare", n_nom, 0);
  endtask

  task automatic scen_stuck_low();
    prep_default();
    preset_img[1] = 8'h00;
    src_img[1]    = 8'h5A;
    commit();
    run_job(1'b0);
    chk("R9", "fail cleared after start", int'(after_start_fail), 0);
    chk("R5", "fail on stuck-low byte", int'(res_fail), 1);
    chk("R5", "strobes on stuck-low byte", pulses_at[1], MP);
    chk("R5", "stuck-low byte unchanged", int'(stored[1]), 0);
  endtask

  task automatic scen_marginal();
    prep_default();
    weak_img[4] = 8'h10;
    commit();
    run_job(1'b0);
    chk("R8", "fail at nominal compare", int'(res_fail), 1);
    chk("R8", "pass", int'(res_pass), 0);
    chk("R8", "all bytes programmed", n_pulses, N);
    chk("R8", "compare stops at bad byte", n_nom, 5);
    chk("R7", "settle violations", v_settle, 0);
  endtask

  task automatic scen_busy_start();
    prep_default();
    commit();
    run_job(1'b1);
    chk("R10", "strobes unchanged", n_pulses, N);
    chk("R10", "single done", n_done, 1);
    chk("R10", "pass", int'(res_pass), 1);
  endtask

  initial begin
    prep_default();
    for (int i = 0; i < N; i++) begin
      stored[i] = 8'hFF;
      pulses_at[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    scen_reset();
    scen_clean();
    scen_retries();
    scen_never();
    scen_stuck_low();
    scen_marginal();
    scen_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end
endmodule